// File: doc/BRIEF.md
# Video RAM Parallel Port Arbiter with Refresh

This block decides which of several agents may drive the parallel port of a video RAM. Five external agents compete for it: split serial-register transfers, full serial-register transfers, the local processor, host slave accesses and bus-master DMA. A sixth contender is internal: a free-running refresh timer. It raises a refresh request each time a programmed interval elapses. When refresh wins, the block drives the RAS/CAS strobes through a complete CAS-before-RAS refresh cycle on its own. When an external agent wins, the block returns a registered one-hot grant and holds it until that agent reports done.

Arbitration happens only while the port is idle, and a grant in progress is never taken away. A split transfer supplies its target address with its request. The block latches that address at grant time and presents it to the port for the whole grant. If the refresh timer expires a second time while an earlier refresh is still waiting for the port, a sticky missed-refresh flag is raised.

Top module: `vram_port_arbiter`

## Requirements
- R1: After reset, `gnt_o` is 0, `port_addr_o` is 0, `ras_n_o` and `cas_n_o` are 1, and `refresh_busy_o` and `missed_refresh_o` are 0.
- R2: Request, done and grant vectors use bit 0 = split transfer, bit 1 = full transfer, bit 2 = processor, bit 3 = host slave, bit 4 = bus-master DMA. When several are requested, the lowest set bit wins.
- R3: A request seen while the port is idle and no refresh is pending yields a one-hot `gnt_o` one clock later. The grant stays unchanged until `done_i` is high on the granted bit; done on any other bit has no effect.
- R4: A grant is never preempted. Requests that arrive during a grant, including higher-priority ones, leave `gnt_o` unchanged.
- R5: The clock edge that samples done on the granted bit clears `gnt_o`. The next grant appears no earlier than one clock after that.
- R6: With `refresh_interval_i` = N > 0, the refresh timer requests a refresh every N clocks, so successive refresh cycles start exactly N clocks apart when the port is otherwise free. N = 0 stops the timer.
- R7: A pending refresh outranks every external request. It starts on the first clock the port is idle. No external grant is given while `refresh_busy_o` is high.
- R8: A refresh cycle runs as follows. CAS falls. RAS falls `cbr_lead_i` clocks later (a value of 0 acts as 1). RAS stays low for RAS_LOW_CYC clocks, then rises. CAS rises one clock after that. Both strobes then stay high for PRE_CYC clocks, after which `refresh_busy_o` drops.
- R9: If the timer expires while an earlier refresh is still pending and not being started, `missed_refresh_o` goes high and stays high until reset.
- R10: While the split transfer (bit 0) holds the grant, `port_addr_o` shows the `split_addr_i` value sampled at grant time and ignores later changes. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| refresh_interval_i | input | IVL_W | Refresh period in clocks; 0 disables the timer |
| cbr_lead_i | input | LEAD_W | Clocks from CAS fall to RAS fall |
| req_i | input | 5 | Request per agent class |
| done_i | input | 5 | Done per agent class |
| split_addr_i | input | ADDR_W | Target address of the split transfer request |
| gnt_o | output | 5 | One-hot grant |
| port_addr_o | output | ADDR_W | Latched split target address, 0 otherwise |
| refresh_busy_o | output | 1 | A refresh cycle owns the port |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| missed_refresh_o | output | 1 | Sticky missed-refresh flag |

## Verification
A corrupted grant register shows on `gnt_o` at the very next edge. It appears either as a second grant bit or as a grant that moves without a matching done. A refresh sequencer that is in the wrong phase or has a miscounted phase counter shows on the strobes within the nine clocks of one refresh cycle: CAS and RAS fall or rise at the wrong offsets. A wrong timer count shows only over a full refresh period, as a wrong spacing between CAS falls. A pending bit that is stuck or lost shows either as a missed-refresh flag set too early or as a refresh that never starts once the port frees up.

// File: rtl/vpa_pkg.sv
package vpa_pkg;
    localparam int NUM_CLS = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_RASLO,
        PH_HOLD,
        PH_PRE
    } cbr_phase_e;
endpackage

// File: rtl/vpa_priority_pick.sv
module vpa_priority_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | req_i[i];
        assign pick_o[i]  = req_i[i] & ~seen[i];
    end
endmodule

// File: rtl/vpa_refresh_timer.sv
module vpa_refresh_timer #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] interval_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic             missed_o
);
    typedef struct packed {
        logic [IVL_W-1:0] cnt;
        logic             pend;
        logic             missed;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (interval_i != '0) && (tmr_q.cnt >= interval_i - IVL_W'(1));
        if (interval_i == '0 || tick) tmr_d.cnt = '0;
        else                          tmr_d.cnt = tmr_q.cnt + IVL_W'(1);
        tmr_d.pend = (tmr_q.pend & ~take_i) | tick;
        if (tick && tmr_q.pend && !take_i) tmr_d.missed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pend_o   = tmr_q.pend;
    assign missed_o = tmr_q.missed;

    a_r9_missed_on_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_o && !take_i) |=> missed_o);
    a_r9_missed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        missed_o |=> missed_o);
endmodule

// File: rtl/vpa_cbr_seq.sv
module vpa_cbr_seq
    import vpa_pkg::*;
#(
    parameter int LEAD_W      = 4,
    parameter int RAS_LOW_CYC = 4,
    parameter int PRE_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEAD_W-1:0] lead_i,
    output logic              busy_o,
    output logic              ras_n_o,
    output logic              cas_n_o
);
    localparam int CW = LEAD_W + $clog2(RAS_LOW_CYC + PRE_CYC + 2);

    typedef struct packed {
        cbr_phase_e    ph;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [LEAD_W-1:0] lead_eff;

    assign lead_eff = (lead_i == '0) ? LEAD_W'(1) : lead_i;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.ph)
            PH_IDLE: if (start_i) begin
                seq_d.ph    = PH_LEAD;
                seq_d.cnt   = CW'(lead_eff) - CW'(1);
                seq_d.cas_n = 1'b0;
            end
            PH_LEAD: if (seq_q.cnt == '0) begin
                seq_d.ph    = PH_RASLO;
                seq_d.cnt   = CW'(RAS_LOW_CYC - 1);
                seq_d.ras_n = 1'b0;
            end else seq_d.cnt = seq_q.cnt - CW'(1);
            PH_RASLO: if (seq_q.cnt == '0) begin
                seq_d.ph    = PH_HOLD;
                seq_d.ras_n = 1'b1;
            end else seq_d.cnt = seq_q.cnt - CW'(1);
            PH_HOLD: begin
                seq_d.ph    = PH_PRE;
                seq_d.cnt   = CW'(PRE_CYC - 1);
                seq_d.cas_n = 1'b1;
            end
            PH_PRE: if (seq_q.cnt == '0) seq_d.ph = PH_IDLE;
                    else seq_d.cnt = seq_q.cnt - CW'(1);
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1};
        else        seq_q <= seq_d;
    end

    assign busy_o  = (seq_q.ph != PH_IDLE);
    assign ras_n_o = seq_q.ras_n;
    assign cas_n_o = seq_q.cas_n;

    a_r8_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o);
    a_r8_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o));
    a_r8_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ras_n_o && cas_n_o));
endmodule

// File: rtl/vram_port_arbiter.sv
module vram_port_arbiter
    import vpa_pkg::*;
#(
    parameter int IVL_W       = 16,
    parameter int LEAD_W      = 4,
    parameter int ADDR_W      = 10,
    parameter int RAS_LOW_CYC = 4,
    parameter int PRE_CYC     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVL_W-1:0]  refresh_interval_i,
    input  logic [LEAD_W-1:0] cbr_lead_i,
    input  logic [4:0]        req_i,
    input  logic [4:0]        done_i,
    input  logic [ADDR_W-1:0] split_addr_i,
    output logic [4:0]        gnt_o,
    output logic [ADDR_W-1:0] port_addr_o,
    output logic              refresh_busy_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              missed_refresh_o
);
    typedef struct packed {
        logic [NUM_CLS-1:0] gnt;
        logic [ADDR_W-1:0]  addr;
    } arb_t;

    arb_t arb_d, arb_q;
    logic [NUM_CLS-1:0] pick;
    logic pend, cbr_busy, port_idle, start_cbr;

    vpa_priority_pick #(.N(NUM_CLS)) u_pick (.req_i(req_i), .pick_o(pick));

    vpa_refresh_timer #(.IVL_W(IVL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .interval_i(refresh_interval_i),
        .take_i(start_cbr), .pend_o(pend), .missed_o(missed_refresh_o));

    vpa_cbr_seq #(.LEAD_W(LEAD_W), .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(PRE_CYC)) u_cbr (
        .clk(clk), .rst_n(rst_n), .start_i(start_cbr), .lead_i(cbr_lead_i),
        .busy_o(cbr_busy), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o));

    assign port_idle = (arb_q.gnt == '0) && !cbr_busy;
    assign start_cbr = port_idle && pend;

    always_comb begin
        arb_d = arb_q;
        if (arb_q.gnt != '0) begin
            if ((arb_q.gnt & done_i) != '0) begin
                arb_d.gnt  = '0;
                arb_d.addr = '0;
            end
        end else if (port_idle && !pend && (req_i != '0)) begin
            arb_d.gnt  = pick;
            arb_d.addr = pick[0] ? split_addr_i : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign gnt_o          = arb_q.gnt;
    assign port_addr_o    = arb_q.addr;
    assign refresh_busy_o = cbr_busy;

    a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));
    a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o != '0) && ((gnt_o & done_i) == '0)) |=> (gnt_o == $past(gnt_o)));
    a_r5_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & done_i) != '0) |=> (gnt_o == '0));
    a_r7_refresh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy_o |-> (gnt_o == '0));
    a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[0] && $past(gnt_o[0])) |-> $stable(port_addr_o));
endmodule

// File: tb/tb_vram_port_arbiter.sv
module tb_vram_port_arbiter;
    localparam int IVL_W = 16, LEAD_W = 4, ADDR_W = 10, RAS_LOW_CYC = 4, PRE_CYC = 2;
    localparam int LEAD = 2;
    localparam int NV = 8;
    localparam logic [9:0] VEC [NV] = '{
        {5'b11111, 5'b00001}, {5'b11110, 5'b00010}, {5'b11100, 5'b00100},
        {5'b11000, 5'b01000}, {5'b10000, 5'b10000}, {5'b10100, 5'b00100},
        {5'b01010, 5'b00010}, {5'b10011, 5'b00001}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [IVL_W-1:0] ivl = '0;
    logic [LEAD_W-1:0] lead = LEAD_W'(LEAD);
    logic [4:0] req = '0, done = '0, gnt;
    logic [ADDR_W-1:0] saddr = 10'h2A5, paddr;
    logic busy, ras_n, cas_n, missed;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vram_port_arbiter #(.IVL_W(IVL_W), .LEAD_W(LEAD_W), .ADDR_W(ADDR_W),
        .RAS_LOW_CYC(RAS_LOW_CYC), .PRE_CYC(PRE_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .refresh_interval_i(ivl), .cbr_lead_i(lead),
        .req_i(req), .done_i(done), .split_addr_i(saddr), .gnt_o(gnt),
        .port_addr_o(paddr), .refresh_busy_o(busy), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .missed_refresh_o(missed));

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; done = '0; ivl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int first, second, t;
        do_reset();
        // R1 reset state
        check(gnt == 0, "R1 gnt", gnt, 0);
        check(paddr == 0, "R1 addr", paddr, 0);
        check(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
        check(!busy && !missed, "R1 flags", {busy, missed}, 0);

        // R2/R3/R5/R10 table walk
        for (int v = 0; v < NV; v++) begin
            req = VEC[v][9:5];
            @(negedge clk);
            check(gnt == VEC[v][4:0], "R2 priority", gnt, VEC[v][4:0]);
            if (VEC[v][0]) begin
                check(paddr == 10'h2A5, "R10 addr", paddr, 10'h2A5);
                saddr = 10'h11B;
                @(negedge clk);
                check(paddr == 10'h2A5, "R10 addr hold", paddr, 10'h2A5);
                saddr = 10'h2A5;
            end else check(paddr == 0, "R10 addr zero", paddr, 0);
            done = VEC[v][4:0]; req = '0;
            @(negedge clk);
            check(gnt == 0, "R5 release", gnt, 0);
            done = '0;
            @(negedge clk);
        end

        // R3/R4: no preemption, foreign done ignored
        req = 5'b10000;
        @(negedge clk);
        check(gnt == 5'b10000, "R3 grant", gnt, 5'b10000);
        req = 5'b11111; done = 5'b01111;
        repeat (3) begin
            @(negedge clk);
            check(gnt == 5'b10000, "R4 no preempt", gnt, 5'b10000);
        end
        done = 5'b10000;
        @(negedge clk);
        check(gnt == 0, "R5 drop", gnt, 0);
        done = '0;
        @(negedge clk);
        check(gnt == 5'b00001, "R5 rearbitrate", gnt, 5'b00001);
        done = 5'b00001; req = '0;
        @(negedge clk);
        done = '0;
        @(negedge clk);

        // R6/R8 refresh waveform and spacing
        ivl = 16'd30;
        first = -1; second = -1;
        for (int i = 0; i < 80 && second < 0; i++) begin
            @(negedge clk);
            if (first < 0 && !cas_n) first = i;
            else if (first >= 0 && second < 0 && !cas_n && i - first > 9) second = i;
            if (first >= 0 && second < 0) begin
                t = i - first;
                if (t < LEAD) check(!cas_n && ras_n && busy, "R8 lead", {cas_n, ras_n}, 1);
                else if (t < LEAD + RAS_LOW_CYC) check(!cas_n && !ras_n, "R8 ras low", {cas_n, ras_n}, 0);
                else if (t == LEAD + RAS_LOW_CYC) check(!cas_n && ras_n, "R8 ras rise", {cas_n, ras_n}, 1);
                else if (t <= LEAD + RAS_LOW_CYC + PRE_CYC) check(cas_n && ras_n && busy, "R8 precharge", {cas_n, ras_n, busy}, 7);
                else if (t == LEAD + RAS_LOW_CYC + PRE_CYC + 1) check(!busy, "R8 done", busy, 0);
            end
        end
        check(second - first == 30, "R6 spacing", second - first, 30);
        check(!missed, "R9 no miss", missed, 0);

        // R9/R7: missed refresh while grant held, then refresh wins
        do_reset();
        req = 5'b00100; ivl = 16'd5;
        repeat (3) @(negedge clk);
        check(!missed, "R9 early", missed, 0);
        repeat (9) @(negedge clk);
        check(missed, "R9 missed", missed, 1);
        check(gnt == 5'b00100 && !busy, "R4 held over refresh", gnt, 5'b00100);
        ivl = '0; req = 5'b11111; done = 5'b00100;
        @(negedge clk);
        done = '0;
        check(gnt == 0, "R5 release", gnt, 0);
        @(negedge clk);
        check(busy && !cas_n && gnt == 0, "R7 refresh first", {busy, cas_n, gnt}, 7'b1000000);
        repeat (12) @(negedge clk);
        check(gnt == 5'b00001 && paddr == 10'h2A5, "R2 after refresh", gnt, 5'b00001);
        check(missed, "R9 sticky", missed, 1);
        req = '0; done = 5'b00001;
        @(negedge clk);
        done = '0;

        // R6: interval 0 stops timer
        do_reset();
        repeat (40) @(negedge clk);
        check(cas_n && !busy, "R6 disabled", {cas_n, busy}, 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule